// File: doc/BRIEF.md
# Warp Memory Access Coalescer

This block accepts one warp-wide memory instruction at a time: 32 per-thread byte addresses in a 40-bit unified address space, an active-thread mask and an addressing-mode flag. Each active address is first placed in one of three spaces. Two fixed windows, set by parameters, select the shared space and the thread-private local space. Any address outside both windows is global. The shared and local results come out once per warp as two thread masks.

The active global accesses are then merged into aligned 128-byte memory-block requests. Each request is sent on a valid/ready stream together with the mask of threads it serves. One request can leave per cycle. The block always picks the lowest-numbered thread still pending, gathers every pending thread whose address falls in the same block, and removes them from the pending set. This gives exactly one request per distinct block, and so the smallest possible number of requests.

The input side is valid/ready. A warp is taken only while the block is idle. On the output side, the request stream may be stalled for any number of cycles by holding `req_ready` low. While stalled, the block holds the current request unchanged. A one-cycle `done` pulse marks the end of each warp.

Top module: `warp_coalescer`

## Requirements
- R1: `in_ready` is 1 exactly when no warp is being processed, and a warp is accepted on a clock edge where `in_valid` and `in_ready` are both 1. `in_ready` is 0 while requests of the accepted warp are still outstanding, and it is 1 after reset.
- R2: One cycle after acceptance, `route_valid` pulses for one cycle. `route_shared` then has bit t set for each active thread t whose effective address lies in [SHARED_BASE, SHARED_BASE+SHARED_SIZE). `route_local` has bit t set for each active thread outside that window and inside [LOCAL_BASE, LOCAL_BASE+LOCAL_SIZE). Inactive threads appear in neither mask.
- R3: An active thread whose effective address lies outside both windows is global. Window bounds are inclusive at the base and exclusive at base plus size.
- R4: When `in_mode32` is 1, address bits 39..32 are treated as zero for both routing and merging. When it is 0, all 40 bits are used.
- R5: Each request carries `req_addr` = the common effective-address bits 39..7 followed by seven zero bits. `req_mask` holds every still-pending global thread whose effective-address bits 39..7 equal those of the request.
- R6: Requests leave in increasing order of their lowest-numbered thread. Each request is led by the lowest-numbered global thread not yet served.
- R7: Every active global thread appears in exactly one request, and the number of requests equals the number of distinct 128-byte blocks among active global threads.
- R8: While `req_valid` is 1 and `req_ready` is 0, `req_valid`, `req_addr` and `req_mask` stay unchanged in the next cycle.
- R9: `done` is a one-cycle pulse in the cycle after the last request handshake. A warp with no active global thread (including an all-zero active mask) produces no request, and its `done` comes two cycles after acceptance.
- R10: The first request of a warp with at least one global thread is valid in the cycle after acceptance, the same cycle as the `route_valid` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Warp instruction present |
| in_ready | output | 1 | Block idle, can take a warp |
| in_mode32 | input | 1 | 1: use only address bits 31..0 |
| in_active | input | 32 | Active-thread mask, bit t for thread t |
| in_addr | input | 1280 | Thread t byte address in bits 40t+39..40t |
| req_valid | output | 1 | Block request available |
| req_ready | input | 1 | Consumer takes the request |
| req_addr | output | 40 | Aligned 128-byte block byte address |
| req_mask | output | 32 | Threads served by this request |
| route_valid | output | 1 | Routing masks valid (one-cycle pulse) |
| route_shared | output | 32 | Active threads in the shared window |
| route_local | output | 32 | Active threads in the local window |
| done | output | 1 | Warp finished (one-cycle pulse) |

## Verification
The routing report and the first merged request appear in the same cycle, the one right after acceptance. The bench samples both at the first falling edge after the accept edge and checks their contents against separate expected queues. Mixed warps with shared, local and global threads in the same instruction show that the route masks and the request masks never claim the same thread. A second overlap is the final request handshake and the `done` pulse on the following cycle. With the consumer always ready, the bench counts cycles from acceptance to `done`. It also checks that the request queue is empty at that point, both for warps with many requests and for warps with no global thread.

// File: rtl/wc_pkg.sv
package wc_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_BUSY = 1'b1
  } wc_state_t;
endpackage

// File: rtl/wc_space_router.sv
module wc_space_router #(
  parameter int          NT       = 32,
  parameter int          AW       = 40,
  parameter int          BS       = 7,
  parameter logic [63:0] SH_BASE  = 64'h0100_0000,
  parameter logic [63:0] SH_SIZE  = 64'h0100_0000,
  parameter logic [63:0] LO_BASE  = 64'h0200_0000,
  parameter logic [63:0] LO_SIZE  = 64'h0100_0000
) (
  input  logic [NT*AW-1:0]      addr_flat,
  input  logic                  mode32,
  input  logic [NT-1:0]         active,
  output logic [NT*(AW-BS)-1:0] blk_flat,
  output logic [NT-1:0]         shared_mask,
  output logic [NT-1:0]         local_mask,
  output logic [NT-1:0]         global_mask
);
  localparam int BW = AW - BS;
  localparam logic [63:0] SH_END = SH_BASE + SH_SIZE;
  localparam logic [63:0] LO_END = LO_BASE + LO_SIZE;

  for (genvar t = 0; t < NT; t++) begin : g_thr
    logic [AW-1:0] ea;
    logic [63:0]   ea64;
    logic          in_sh;
    logic          in_lo;

    always_comb begin
      ea = addr_flat[t*AW +: AW];
      if (mode32) begin
        for (int b = 32; b < AW; b++) ea[b] = 1'b0;
      end
    end

    assign ea64  = 64'(ea);
    assign in_sh = (ea64 >= SH_BASE) && (ea64 < SH_END);
    assign in_lo = (ea64 >= LO_BASE) && (ea64 < LO_END);

    assign shared_mask[t]         = active[t] & in_sh;
    assign local_mask[t]          = active[t] & ~in_sh & in_lo;
    assign global_mask[t]         = active[t] & ~in_sh & ~in_lo;
    assign blk_flat[t*BW +: BW]   = ea[AW-1:BS];
  end
endmodule

// File: rtl/wc_leader_pick.sv
module wc_leader_pick #(
  parameter int NT = 32,
  localparam int LW = (NT > 1) ? $clog2(NT) : 1
) (
  input  logic [NT-1:0] pending,
  output logic [LW-1:0] idx,
  output logic          found
);
  always_comb begin
    idx   = '0;
    found = 1'b0;
    for (int i = NT - 1; i >= 0; i--) begin
      if (pending[i]) begin
        idx   = LW'(i);
        found = 1'b1;
      end
    end
  end
endmodule

// File: rtl/wc_block_match.sv
module wc_block_match #(
  parameter int NT = 32,
  parameter int BW = 33,
  localparam int LW = (NT > 1) ? $clog2(NT) : 1
) (
  input  logic [NT*BW-1:0] blk_flat,
  input  logic [NT-1:0]    pending,
  input  logic [LW-1:0]    leader,
  output logic [BW-1:0]    leader_blk,
  output logic [NT-1:0]    match
);
  assign leader_blk = blk_flat[leader*BW +: BW];

  for (genvar t = 0; t < NT; t++) begin : g_cmp
    assign match[t] = pending[t] && (blk_flat[t*BW +: BW] == leader_blk);
  end
endmodule

// File: rtl/warp_coalescer.sv
module warp_coalescer
  import wc_pkg::*;
#(
  parameter int          NUM_THREADS = 32,
  parameter int          ADDR_W      = 40,
  parameter int          BLK_SHIFT   = 7,
  parameter logic [63:0] SHARED_BASE = 64'h0100_0000,
  parameter logic [63:0] SHARED_SIZE = 64'h0100_0000,
  parameter logic [63:0] LOCAL_BASE  = 64'h0200_0000,
  parameter logic [63:0] LOCAL_SIZE  = 64'h0100_0000
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          in_valid,
  output logic                          in_ready,
  input  logic                          in_mode32,
  input  logic [NUM_THREADS-1:0]        in_active,
  input  logic [NUM_THREADS*ADDR_W-1:0] in_addr,
  output logic                          req_valid,
  input  logic                          req_ready,
  output logic [ADDR_W-1:0]             req_addr,
  output logic [NUM_THREADS-1:0]        req_mask,
  output logic                          route_valid,
  output logic [NUM_THREADS-1:0]        route_shared,
  output logic [NUM_THREADS-1:0]        route_local,
  output logic                          done
);
  localparam int NT = NUM_THREADS;
  localparam int BW = ADDR_W - BLK_SHIFT;
  localparam int LW = (NT > 1) ? $clog2(NT) : 1;

  wc_state_t        state_q;
  logic [NT*BW-1:0] blk_q;
  logic [NT-1:0]    pend_q;
  logic             route_valid_q;
  logic [NT-1:0]    route_sh_q, route_lo_q;
  logic             done_q;

  logic [NT*BW-1:0] rt_blk;
  logic [NT-1:0]    rt_sh, rt_lo, rt_gl;
  logic [LW-1:0]    lead_idx;
  logic             lead_found;
  logic [BW-1:0]    lead_blk;
  logic [NT-1:0]    match;

  logic busy, accept, fire, last;

  wc_space_router #(
    .NT(NT), .AW(ADDR_W), .BS(BLK_SHIFT),
    .SH_BASE(SHARED_BASE), .SH_SIZE(SHARED_SIZE),
    .LO_BASE(LOCAL_BASE), .LO_SIZE(LOCAL_SIZE)
  ) u_router (
    .addr_flat  (in_addr),
    .mode32     (in_mode32),
    .active     (in_active),
    .blk_flat   (rt_blk),
    .shared_mask(rt_sh),
    .local_mask (rt_lo),
    .global_mask(rt_gl)
  );

  wc_leader_pick #(.NT(NT)) u_leader (
    .pending(pend_q),
    .idx    (lead_idx),
    .found  (lead_found)
  );

  wc_block_match #(.NT(NT), .BW(BW)) u_match (
    .blk_flat  (blk_q),
    .pending   (pend_q),
    .leader    (lead_idx),
    .leader_blk(lead_blk),
    .match     (match)
  );

  assign busy     = (state_q == ST_BUSY);
  assign in_ready = ~busy;
  assign accept   = in_valid & in_ready;

  assign req_valid = busy & lead_found;
  assign req_addr  = {lead_blk, {BLK_SHIFT{1'b0}}};
  assign req_mask  = match;
  assign fire      = req_valid & req_ready;
  assign last      = busy && ((pend_q & ~(fire ? match : '0)) == '0);

  assign route_valid  = route_valid_q;
  assign route_shared = route_sh_q;
  assign route_local  = route_lo_q;
  assign done         = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q       <= ST_IDLE;
      blk_q         <= '0;
      pend_q        <= '0;
      route_valid_q <= 1'b0;
      route_sh_q    <= '0;
      route_lo_q    <= '0;
      done_q        <= 1'b0;
    end else begin
      route_valid_q <= 1'b0;
      done_q        <= 1'b0;
      if (accept) begin
        state_q       <= ST_BUSY;
        blk_q         <= rt_blk;
        pend_q        <= rt_gl;
        route_valid_q <= 1'b1;
        route_sh_q    <= rt_sh;
        route_lo_q    <= rt_lo;
      end else if (busy) begin
        if (fire) pend_q <= pend_q & ~match;
        if (last) begin
          state_q <= ST_IDLE;
          done_q  <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/wc_checker.sv
module wc_checker #(
  parameter int NT = 32,
  parameter int AW = 40,
  parameter int BS = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_ready,
  input logic          req_valid,
  input logic          req_ready,
  input logic [AW-1:0] req_addr,
  input logic [NT-1:0] req_mask,
  input logic          route_valid,
  input logic [NT-1:0] route_shared,
  input logic [NT-1:0] route_local,
  input logic          done
);
  AST_BUSY_NO_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> !in_ready); // R1

  AST_ROUTE_DISJOINT: assert property (@(posedge clk) disable iff (!rst_n)
    route_valid |-> ((route_shared & route_local) == '0)); // R2

  AST_ROUTE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    route_valid |=> !route_valid); // R2

  AST_REQ_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_addr[BS-1:0] == '0) && (req_mask != '0)); // R5

  AST_NO_REPEAT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_valid || ((req_mask & $past(req_mask)) == '0)); // R7

  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> req_valid && $stable(req_addr) && $stable(req_mask)); // R8

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> in_ready && !req_valid); // R9
endmodule

bind warp_coalescer wc_checker #(
  .NT(NUM_THREADS), .AW(ADDR_W), .BS(BLK_SHIFT)
) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_ready    (in_ready),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .req_addr    (req_addr),
  .req_mask    (req_mask),
  .route_valid (route_valid),
  .route_shared(route_shared),
  .route_local (route_local),
  .done        (done)
);

// File: tb/warp_coalescer_tb_top.sv
module warp_coalescer_tb_top;
  localparam int NT = 32;
  localparam int AW = 40;
  localparam logic [63:0] SH_B = 64'h0100_0000;
  localparam logic [63:0] SH_S = 64'h0100_0000;
  localparam logic [63:0] LO_B = 64'h0200_0000;
  localparam logic [63:0] LO_S = 64'h0100_0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic in_mode32 = 1'b0;
  logic [NT-1:0] in_active = '0;
  logic [NT*AW-1:0] in_addr;
  logic req_valid;
  logic req_ready = 1'b1;
  logic [AW-1:0] req_addr;
  logic [NT-1:0] req_mask;
  logic route_valid;
  logic [NT-1:0] route_shared, route_local;
  logic done;

  logic [AW-1:0] taddr [NT];
  bit stall_mode = 1'b0;
  int n_chk = 0;
  int n_fail = 0;

  logic [71:0] exp_q [$];
  logic [63:0] route_q [$];

  always #10 clk = ~clk;

  always_comb begin
    for (int i = 0; i < NT; i++) in_addr[i*AW +: AW] = taddr[i];
  end

  warp_coalescer dut_i (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_mode32(in_mode32),
    .in_active(in_active), .in_addr(in_addr),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_mask(req_mask),
    .route_valid(route_valid), .route_shared(route_shared),
    .route_local(route_local), .done(done)
  );

  task automatic chk(input bit ok, input string rq, input logic [71:0] act, input logic [71:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", rq, act, expv);
    end
  endtask

  // ready driver: random stalls when stall_mode is set
  always begin
    @(posedge clk);
    #1;
    req_ready = stall_mode ? ($urandom_range(0, 2) != 0) : 1'b1;
  end

  // monitor: pops the scoreboard as results appear
  logic        prev_stall = 1'b0;
  logic [71:0] prev_req = '0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_stall)
        chk(req_valid && ({req_addr, req_mask} == prev_req), "R8 stalled request held",
            {req_addr, req_mask}, prev_req);
      if (req_valid && req_ready) begin
        if (exp_q.size() == 0)
          chk(1'b0, "R7 unexpected extra request", {req_addr, req_mask}, '0);
        else begin
          logic [71:0] e;
          e = exp_q.pop_front();
          chk({req_addr, req_mask} == e, "R5/R6 request addr/mask", {req_addr, req_mask}, e);
        end
      end
      if (route_valid) begin
        if (route_q.size() == 0)
          chk(1'b0, "R2 unexpected route pulse", {8'h0, route_shared, route_local}, '0);
        else begin
          logic [63:0] r;
          r = route_q.pop_front();
          chk({route_shared, route_local} == r, "R2/R3 route masks",
              {8'h0, route_shared, route_local}, {8'h0, r});
        end
      end
      prev_stall = req_valid && !req_ready;
      prev_req   = {req_addr, req_mask};
    end
  end

  // driver: builds expected results from the requirements, then sends the warp
  task automatic run_warp(input logic [NT-1:0] act, input bit m32, input bit stall);
    logic [AW-1:0] ea [NT];
    logic [NT-1:0] sh, lo, pend;
    int k;
    int n;
    bit got_done;
    sh = '0; lo = '0; pend = '0; k = 0;
    for (int i = 0; i < NT; i++) begin
      ea[i] = taddr[i];
      if (m32) ea[i][AW-1:32] = '0;
      if (act[i]) begin
        if (64'(ea[i]) >= SH_B && 64'(ea[i]) < SH_B + SH_S) sh[i] = 1'b1;
        else if (64'(ea[i]) >= LO_B && 64'(ea[i]) < LO_B + LO_S) lo[i] = 1'b1;
        else pend[i] = 1'b1;
      end
    end
    route_q.push_back({sh, lo});
    for (int i = 0; i < NT; i++) begin
      if (pend[i]) begin
        logic [NT-1:0] m;
        m = '0;
        for (int j = i; j < NT; j++)
          if (pend[j] && ea[j][AW-1:7] == ea[i][AW-1:7]) m[j] = 1'b1;
        exp_q.push_back({ea[i][AW-1:7], 7'b0, m});
        pend = pend & ~m;
        k++;
      end
    end
    stall_mode = stall;
    @(posedge clk);
    #1;
    in_active = act;
    in_mode32 = m32;
    in_valid  = 1'b1;
    @(negedge clk);
    chk(in_ready, "R1 idle before warp", {71'h0, in_ready}, 72'h1);
    @(posedge clk);
    #1;
    in_valid = 1'b0;
    n = 0;
    got_done = 1'b0;
    while (!got_done && n < 3000) begin
      @(negedge clk);
      n++;
      if (n == 1) begin
        chk(route_valid, "R10 route pulse after accept", {71'h0, route_valid}, 72'h1);
        if (k > 0) chk(req_valid, "R10 first request after accept", {71'h0, req_valid}, 72'h1);
        else chk(!req_valid, "R9 no request for non-global warp", {71'h0, req_valid}, 72'h0);
        if (k > 1) chk(!in_ready, "R1 busy blocks acceptance", {71'h0, in_ready}, 72'h0);
      end
      if (done) got_done = 1'b1;
    end
    chk(got_done, "R9 done seen", {71'h0, got_done}, 72'h1);
    if (!stall)
      chk(n == ((k == 0) ? 2 : k + 1), "R9 done timing", 72'(n), 72'((k == 0) ? 2 : k + 1));
    chk(exp_q.size() == 0, "R7 all requests delivered", 72'(exp_q.size()), 72'h0);
    stall_mode = 1'b0;
  endtask

  initial begin
    #(20 * 150000);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < NT; i++) taddr[i] = '0;
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready && !req_valid && !done && !route_valid, "R1 reset state",
        {68'h0, in_ready, req_valid, done, route_valid}, 72'h8);

    // same block for all threads: one request (R5, R7)
    for (int i = 0; i < NT; i++) taddr[i] = 40'h12_3456_7800 + 40'(i * 4);
    run_warp('1, 1'b0, 1'b0);

    // distinct blocks in thread order (R6, R7)
    for (int i = 0; i < NT; i++) taddr[i] = 40'h80_0000_0000 + 40'(i * 128);
    run_warp('1, 1'b0, 1'b0);

    // mixed spaces with partial active mask (R2, R3)
    for (int i = 0; i < NT; i++) begin
      case (i % 4)
        0: taddr[i] = 40'h00_0100_0000 + 40'(i * 8);
        1: taddr[i] = 40'h00_0200_0040 + 40'(i);
        2: taddr[i] = 40'h05_0000_0000 + 40'(i);
        default: taddr[i] = 40'h05_0000_0080 + 40'(i);
      endcase
    end
    run_warp(32'hF0F0_FF0F, 1'b0, 1'b0);

    // window edges (R3)
    for (int i = 0; i < NT; i++) taddr[i] = 40'h00_0400_0000;
    taddr[0] = 40'h00_00FF_FFFF;
    taddr[1] = 40'h00_0100_0000;
    taddr[2] = 40'h00_01FF_FFFF;
    taddr[3] = 40'h00_0200_0000;
    taddr[4] = 40'h00_02FF_FFFF;
    taddr[5] = 40'h00_0300_0000;
    run_warp('1, 1'b0, 1'b0);

    // empty active mask (R9)
    run_warp('0, 1'b0, 1'b0);

    // all shared: no request (R9, R2)
    for (int i = 0; i < NT; i++) taddr[i] = 40'h00_0100_0000 + 40'(i * 256);
    run_warp('1, 1'b0, 1'b0);

    // upper bits differ; 32-bit mode merges them (R4)
    for (int i = 0; i < NT; i++)
      taddr[i] = {8'(i + 1), 32'h0300_0000 + 32'((i % 2) * 128)};
    taddr[5] = {8'hAA, 32'h0100_0010};
    run_warp('1, 1'b1, 1'b0);
    run_warp('1, 1'b0, 1'b0);

    // interleaved blocks under back-pressure (R6, R8)
    for (int i = 0; i < NT; i++) taddr[i] = 40'h33_0000_0000 + 40'(((i * 7) % 5) * 128 + i);
    run_warp(32'hBFFF_FFFE, 1'b0, 1'b1);
    for (int i = 0; i < NT; i++) taddr[i] = 40'h80_0000_0000 + 40'((NT - 1 - i) * 128);
    run_warp('1, 1'b0, 1'b1);

    repeat (3) @(negedge clk);
    chk(route_q.size() == 0, "R2 route queue drained", 72'(route_q.size()), 72'h0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule